// File: doc/BRIEF.md
# Associative Translation Lookaside Buffer

This block is a small, fully associative store for recently used page-to-frame translations. Each line keeps a virtual page number, the physical frame it maps to, and the two permission bits copied from the page table: the entry-valid bit and the write-permission bit. A separate occupancy flag per line records whether the line holds anything at all.

A lookup is purely combinational. The presented page number is compared against every occupied line in parallel, and the block returns the frame and the two permission bits of the matching line, or raises a miss. A miss handler loads a line by presenting the whole entry, naming the target line and pulsing a write strobe. A round-robin counter offers a suggested victim line that the handler may use. A flush input empties the whole buffer in one cycle.

Top module: `tlb_assoc`

## Requirements
- R1: After reset no line is occupied, every lookup misses, and the suggested victim line is 0.
- R2: When `fill_we` is high at a rising clock edge, the line numbered `fill_line` takes the presented page, frame, entry-valid and write-permission values and becomes occupied. From the following cycle a lookup of that page returns `lk_miss`=0, the stored frame, `lk_pvalid` and `lk_wperm`.
- R3: `lk_miss` is 1 exactly when no occupied line holds `lk_page`. While it is 1, `lk_frame`, `lk_pvalid` and `lk_wperm` are all 0.
- R4: An unoccupied line never matches, even when its stale page field equals the presented page.
- R5: A fill of an occupied line replaces its previous entry, and the old page then misses unless another line holds it.
- R6: A cycle with `flush` high leaves every line unoccupied from the next cycle on.
- R7: When `flush` and `fill_we` are high in the same cycle, the flush wins. No line is occupied afterwards, and the suggested victim does not move.
- R8: The suggested victim advances by one on each accepted fill and wraps from the last line (7) back to 0. It does not change in cycles without an accepted fill.
- R9: When more than one occupied line holds the presented page, the line with the lowest number supplies the outputs.
- R10: With `fill_we` low and `flush` low, nothing that a lookup can observe changes, whatever the fill data inputs carry.
- R11: The entry-valid bit does not affect matching. A line filled with `fill_pvalid`=0 still hits and reports `lk_pvalid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all occupancy flags |
| lk_page | input | 20 | Page number to translate |
| lk_miss | output | 1 | No occupied line holds `lk_page` |
| lk_frame | output | 20 | Frame of the matching line |
| lk_pvalid | output | 1 | Entry-valid bit of the matching line |
| lk_wperm | output | 1 | Write-permission bit of the matching line |
| fill_we | input | 1 | Write strobe for a line fill |
| fill_line | input | 3 | Line to be written |
| fill_page | input | 20 | Page number to store |
| fill_frame | input | 20 | Frame number to store |
| fill_pvalid | input | 1 | Entry-valid bit to store |
| fill_wperm | input | 1 | Write-permission bit to store |
| victim_line | output | 3 | Round-robin suggested line for the next fill |

## Verification
Flush and fill can land in the same cycle. The bench provokes this by raising both strobes together on a buffer that already holds entries. It judges the outcome at the ports: the page just offered and the pages held before both miss on the next cycle, and the suggested victim keeps its value. A second pairing is a fill to one line while a lookup hits another line for the same page. Here the bench checks that the lowest-numbered line supplies the outputs both before and after the new entry arrives.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int MAX_LINES = 32;

  // Isolate the lowest set bit of a hit vector (priority to line 0).
  function automatic logic [MAX_LINES-1:0] lowest_one(input logic [MAX_LINES-1:0] v);
    return v & (~v + MAX_LINES'(1));
  endfunction

  // Round-robin successor with wrap at the line count.
  function automatic int unsigned rr_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/tlb_line.sv
module tlb_line #(
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_pvalid,
  input  logic               wr_wperm,
  input  logic [PAGE_W-1:0]  cmp_page,
  output logic               occ,
  output logic               hit,
  output logic [FRAME_W-1:0] rd_frame,
  output logic               rd_pvalid,
  output logic               rd_wperm
);

  logic [PAGE_W-1:0]  page_q;
  logic [FRAME_W-1:0] frame_q;
  logic               pvalid_q;
  logic               wperm_q;
  logic               occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      occ_q <= 1'b0;
    else if (flush)  occ_q <= 1'b0;
    else if (wr)     occ_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      frame_q  <= '0;
      pvalid_q <= 1'b0;
      wperm_q  <= 1'b0;
    end else if (wr && !flush) begin
      page_q   <= wr_page;
      frame_q  <= wr_frame;
      pvalid_q <= wr_pvalid;
      wperm_q  <= wr_wperm;
    end
  end

  assign occ       = occ_q;
  assign hit       = occ_q && (page_q == cmp_page);
  assign rd_frame  = frame_q;
  assign rd_pvalid = pvalid_q;
  assign rd_wperm  = wperm_q;

endmodule

// File: rtl/tlb_select.sv
module tlb_select
  import tlb_pkg::*;
#(
  parameter int NLINES  = 8,
  parameter int FRAME_W = 20
) (
  input  logic [NLINES-1:0]              hit_vec,
  input  logic [NLINES-1:0][FRAME_W-1:0] frames,
  input  logic [NLINES-1:0]              pvalids,
  input  logic [NLINES-1:0]              wperms,
  output logic [NLINES-1:0]              sel_onehot,
  output logic                           miss,
  output logic [FRAME_W-1:0]             frame,
  output logic                           pvalid,
  output logic                           wperm
);

  logic [MAX_LINES-1:0] wide_sel;

  assign wide_sel   = lowest_one(MAX_LINES'(hit_vec));
  assign sel_onehot = wide_sel[NLINES-1:0];
  assign miss       = (sel_onehot == '0);

  always_comb begin
    frame  = '0;
    pvalid = 1'b0;
    wperm  = 1'b0;
    for (int i = 0; i < NLINES; i++) begin
      frame  = frame | (frames[i] & {FRAME_W{sel_onehot[i]}});
      pvalid = pvalid | (pvalids[i] & sel_onehot[i]);
      wperm  = wperm | (wperms[i] & sel_onehot[i]);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] victim
);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (step) ptr_q <= IDX_W'(rr_next(int'(ptr_q), NLINES));
  end

  assign victim = ptr_q;

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int NLINES  = 8,
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 20,
  localparam int IDX_W  = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               lk_miss,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_pvalid,
  output logic               lk_wperm,
  input  logic               fill_we,
  input  logic [IDX_W-1:0]   fill_line,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_pvalid,
  input  logic               fill_wperm,
  output logic [IDX_W-1:0]   victim_line
);

  // Named internal events, visible to the bound checker.
  logic [NLINES-1:0]              wr_vec;
  logic [NLINES-1:0]              occ_vec;
  logic [NLINES-1:0]              hit_vec;
  logic [NLINES-1:0]              sel_onehot;
  logic [NLINES-1:0][FRAME_W-1:0] frame_vec;
  logic [NLINES-1:0]              pvalid_vec;
  logic [NLINES-1:0]              wperm_vec;
  logic                           fill_accept;

  assign fill_accept = fill_we && !flush;

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line
      assign wr_vec[g] = fill_we && (fill_line == IDX_W'(g));

      tlb_line #(
        .PAGE_W (PAGE_W),
        .FRAME_W(FRAME_W)
      ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr       (wr_vec[g]),
        .wr_page  (fill_page),
        .wr_frame (fill_frame),
        .wr_pvalid(fill_pvalid),
        .wr_wperm (fill_wperm),
        .cmp_page (lk_page),
        .occ      (occ_vec[g]),
        .hit      (hit_vec[g]),
        .rd_frame (frame_vec[g]),
        .rd_pvalid(pvalid_vec[g]),
        .rd_wperm (wperm_vec[g])
      );
    end
  endgenerate

  tlb_select #(
    .NLINES (NLINES),
    .FRAME_W(FRAME_W)
  ) u_select (
    .hit_vec   (hit_vec),
    .frames    (frame_vec),
    .pvalids   (pvalid_vec),
    .wperms    (wperm_vec),
    .sel_onehot(sel_onehot),
    .miss      (lk_miss),
    .frame     (lk_frame),
    .pvalid    (lk_pvalid),
    .wperm     (lk_wperm)
  );

  tlb_victim #(
    .NLINES(NLINES),
    .IDX_W (IDX_W)
  ) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (fill_accept),
    .victim(victim_line)
  );

endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
  parameter int NLINES  = 8,
  parameter int FRAME_W = 20,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               fill_we,
  input logic [IDX_W-1:0]   fill_line,
  input logic               lk_miss,
  input logic [FRAME_W-1:0] lk_frame,
  input logic               lk_pvalid,
  input logic               lk_wperm,
  input logic [IDX_W-1:0]   victim_line,
  input logic [NLINES-1:0]  occ_vec,
  input logic [NLINES-1:0]  hit_vec,
  input logic [NLINES-1:0]  sel_onehot
);

  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> (occ_vec == '0) && (victim_line == '0));

  a_r2_fill_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !flush && (int'(fill_line) < NLINES)) |=> occ_vec[$past(fill_line)]);

  a_r3_miss_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_frame == '0) && !lk_pvalid && !lk_wperm);

  a_r3_miss_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (hit_vec == '0));

  a_r4_hit_needs_occ: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~occ_vec) == '0);

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ_vec == '0));

  a_r7_flush_holds_victim: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> $stable(victim_line));

  a_r8_victim_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !flush) |=>
      (victim_line == (($past(victim_line) == IDX_W'(NLINES-1)) ? '0 : $past(victim_line) + IDX_W'(1))));

  a_r8_victim_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_we |=> $stable(victim_line));

  a_r9_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_onehot) && ((sel_onehot & ~hit_vec) == '0));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_we && !flush) |=> $stable(occ_vec));

endmodule

bind tlb_assoc tlb_assoc_chk #(
  .NLINES (NLINES),
  .FRAME_W(FRAME_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .fill_we    (fill_we),
  .fill_line  (fill_line),
  .lk_miss    (lk_miss),
  .lk_frame   (lk_frame),
  .lk_pvalid  (lk_pvalid),
  .lk_wperm   (lk_wperm),
  .victim_line(victim_line),
  .occ_vec    (occ_vec),
  .hit_vec    (hit_vec),
  .sel_onehot (sel_onehot)
);

// File: tb/tlb_assoc_tb.sv
module tlb_assoc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;

  typedef struct {
    logic        miss;
    logic [19:0] frame;
    logic        pv;
    logic        wp;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [19:0] lk_page = '0;
  logic        lk_miss;
  logic [19:0] lk_frame;
  logic        lk_pvalid;
  logic        lk_wperm;
  logic        fill_we = 1'b0;
  logic [2:0]  fill_line = '0;
  logic [19:0] fill_page = '0;
  logic [19:0] fill_frame = '0;
  logic        fill_pvalid = 1'b0;
  logic        fill_wperm = 1'b0;
  logic [2:0]  victim_line;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Reference state held by the bench.
  bit          m_occ [NL];
  logic [19:0] m_page[NL];
  logic [19:0] m_frame[NL];
  bit          m_pv [NL];
  bit          m_wp [NL];
  int          m_vic = 0;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_assoc u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_page(lk_page), .lk_miss(lk_miss), .lk_frame(lk_frame),
    .lk_pvalid(lk_pvalid), .lk_wperm(lk_wperm),
    .fill_we(fill_we), .fill_line(fill_line), .fill_page(fill_page),
    .fill_frame(fill_frame), .fill_pvalid(fill_pvalid), .fill_wperm(fill_wperm),
    .victim_line(victim_line)
  );

  function automatic exp_t predict(input logic [19:0] pg, input string tag);
    exp_t e;
    e.miss = 1'b1; e.frame = '0; e.pv = 1'b0; e.wp = 1'b0; e.tag = tag;
    for (int i = NL - 1; i >= 0; i--) begin
      if (m_occ[i] && m_page[i] == pg) begin
        e.miss = 1'b0; e.frame = m_frame[i]; e.pv = m_pv[i]; e.wp = m_wp[i];
      end
    end
    return e;
  endfunction

  // Driver: present a page, push its expected result for the monitor.
  task automatic lookup(input logic [19:0] pg, input string tag);
    lk_page = pg;
    sb_q.push_back(predict(pg, tag));
    @(posedge clk); #2;
  endtask

  // Monitor: compares in the middle of each cycle.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_tests++;
      if (lk_miss !== e.miss || lk_frame !== e.frame ||
          lk_pvalid !== e.pv || lk_wperm !== e.wp) begin
        n_fail++;
        $display("FAIL %s: got miss=%0b frame=%05h pv=%0b wp=%0b, expected miss=%0b frame=%05h pv=%0b wp=%0b",
                 e.tag, lk_miss, lk_frame, lk_pvalid, lk_wperm, e.miss, e.frame, e.pv, e.wp);
      end
    end
  end

  task automatic do_fill(input int ln, input logic [19:0] pg, input logic [19:0] fr,
                         input bit pv, input bit wp, input bit with_flush);
    fill_we = 1'b1; fill_line = 3'(ln); fill_page = pg; fill_frame = fr;
    fill_pvalid = pv; fill_wperm = wp; flush = with_flush;
    @(posedge clk); #2;
    fill_we = 1'b0; flush = 1'b0;
    if (with_flush) begin
      for (int i = 0; i < NL; i++) m_occ[i] = 0;
    end else begin
      m_occ[ln] = 1; m_page[ln] = pg; m_frame[ln] = fr; m_pv[ln] = pv; m_wp[ln] = wp;
      m_vic = (m_vic + 1) % NL;
    end
  endtask

  task automatic check_victim(input string tag);
    n_tests++;
    if (victim_line !== 3'(m_vic)) begin
      n_fail++;
      $display("FAIL %s: victim got %0d expected %0d", tag, victim_line, m_vic);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_occ[i] = 0; m_page[i] = '0; m_frame[i] = '0; m_pv[i] = 0; m_wp[i] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 / R4: empty after reset; page 0 equals stale reset contents yet misses.
    check_victim("R1 victim after reset");
    lookup(20'h00000, "R4 page 0 on empty line");
    lookup(20'h12345, "R1 lookup after reset");

    // R2 / R8
    do_fill(0, 20'hAAAAA, 20'h11111, 1, 1, 0);
    lookup(20'hAAAAA, "R2 hit after fill");
    check_victim("R8 victim after one fill");

    // R11: entry-valid 0 still hits
    do_fill(3, 20'hBBBBB, 20'h22222, 0, 0, 0);
    lookup(20'hBBBBB, "R11 invalid entry still hits");
    lookup(20'hCCCCC, "R3 miss blanks outputs");

    // R10: strobe low with junk fill data
    fill_line = 3'd0; fill_page = 20'hDDDDD; fill_frame = 20'h99999;
    fill_pvalid = 0; fill_wperm = 0;
    repeat (2) @(posedge clk); #2;
    lookup(20'hAAAAA, "R10 idle strobe keeps line 0");
    lookup(20'hDDDDD, "R10 idle strobe no new page");
    check_victim("R10 victim steady while idle");

    // R5: overwrite line 0
    do_fill(0, 20'hDDDDD, 20'h33333, 1, 0, 0);
    lookup(20'hAAAAA, "R5 old page gone");
    lookup(20'hDDDDD, "R5 new page present");

    // R9: duplicates, lowest line wins
    do_fill(5, 20'hBBBBB, 20'h44444, 1, 1, 0);
    lookup(20'hBBBBB, "R9 line 3 beats line 5");
    do_fill(1, 20'hBBBBB, 20'h55555, 1, 0, 0);
    lookup(20'hBBBBB, "R9 line 1 beats line 3");
    check_victim("R8 victim after five fills");

    // R8 wrap
    do_fill(2, 20'h00002, 20'h60002, 1, 1, 0);
    do_fill(4, 20'h00004, 20'h60004, 1, 1, 0);
    check_victim("R8 victim at last line");
    do_fill(6, 20'h00006, 20'h60006, 0, 1, 0);
    check_victim("R8 victim wrap to 0");
    for (int i = 0; i < NL; i++) lookup(m_page[i], "R2 sweep of stored pages");

    // R6: flush alone
    flush = 1'b1;
    @(posedge clk); #2;
    flush = 1'b0;
    for (int i = 0; i < NL; i++) m_occ[i] = 0;
    lookup(20'hDDDDD, "R6 flush empties");
    lookup(20'h00004, "R6 flush empties");
    check_victim("R6 victim kept by flush");

    // R7: flush and fill together
    do_fill(7, 20'h77777, 20'h70000, 1, 1, 0);
    lookup(20'h77777, "R2 fill after flush");
    do_fill(2, 20'h88888, 20'h80000, 1, 1, 1);
    lookup(20'h88888, "R7 fill lost to flush");
    lookup(20'h77777, "R7 old entry flushed");
    check_victim("R7 victim held");

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule